// File: doc/BRIEF.md
# SGMII PCS Bring-Up Sequencer

This block is a hardware sequencer that brings up an SGMII physical coding sublayer and its GMII-to-SGMII adapter over a 16-bit register master port, so no software driver is needed. After an init pulse it puts the PCS into SGMII mode and loads the 32-bit link timer as two halves. It then starts a self-clearing soft reset and polls until the reset bit clears. It enables the adapter only if the reset completed before the timeout.

A link-adjust pulse first disables the adapter. It then configures the PCS for either auto-negotiation or a forced speed, soft-resets it, and waits a fixed settle interval. Next it reads the status register and, with auto-negotiation, the link-partner ability register. The adapter is enabled again only when the result is usable: a full-duplex partner at a valid speed, or a forced link that is up. Done, error and the decoded partner speed and duplex stay on the outputs until the next request is accepted. Intervals are counted in clock cycles from a cycles-per-millisecond parameter.

The register port is a valid/ready request channel with a response strobe. A request keeps its address, write flag and write data steady while `reg_req_valid` is high and `reg_req_ready` is low. Only one access is outstanding at a time. Every access, read or write, ends with one `reg_rsp_valid` pulse. The response carries no back-pressure, because the block always accepts it.

Top module: `pcs_bringup_seq`

## Requirements
- R1: While reg_req_valid is high and reg_req_ready is low, the request holds all its fields. A new request is issued only after the previous access has received its response pulse.
- R2: An init pulse writes 0x0001 to register 0x28, then 0x0D40 to 0x24, then 0x0003 to 0x26, in that order and as the first three accesses.
- R3: Each soft reset reads control register 0x00 and writes the value back with bit 15 set and all other bits preserved. It then reads 0x00 again until bit 15 reads 0.
- R4: If bit 15 still reads 1 once RST_TIMEOUT_MS*CYC_PER_MS cycles have passed since the reset write, the block raises seq_done and seq_error and does not enable the adapter.
- R5: After a successful init reset, the block writes 0x0000 (enable) to the adapter register at ADAPTER_ADDR (default 0x40), then raises seq_done with seq_error low.
- R6: The first access of every link-adjust request writes 0x0001 (disable) to the adapter register.
- R7: In auto-negotiation mode (adj_autoneg=1), the block sets bit 12 of register 0x00 and bit 1 of register 0x28 by read-modify-write, then soft-resets.
- R8: In forced mode, the block clears bit 12 of 0x00, clears bit 1 of 0x28, and writes adj_speed into bits [3:2] of 0x28 (2'b10 = 1000, 2'b01 = 100, 2'b00 = 10 Mb/s), keeping bit 0, then soft-resets. A forced speed of 2'b11 ends with an error, with no reset and the adapter left disabled.
- R9: After the adjust reset clears, at least SETTLE_MS*CYC_PER_MS cycles pass before status register 0x02 is read.
- R10: In auto-negotiation mode, status bit 5 low gives an error. Otherwise the partner ability register 0x0A is read: bit 12 is duplex (1 = full) and bits [11:10] are speed with the R8 encoding. Both are reported on lp_full and lp_speed, and the adapter is enabled only for full duplex with a speed other than 2'b11, else error.
- R11: In forced mode, status bit 2 high enables the adapter with no error, otherwise error. lp_speed and lp_full read 0.
- R12: Out of reset seq_done, seq_error and reg_req_valid are 0. At the end of a request seq_done rises, and done, error and partner outputs hold until the next accepted request, with no bus traffic while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_start | input | 1 | Pulse: run the init sequence (takes priority) |
| adj_req | input | 1 | Pulse: run the link-adjust sequence |
| adj_autoneg | input | 1 | Adjust mode, 1 = auto-negotiation, sampled with adj_req |
| adj_speed | input | 2 | Forced speed code, sampled with adj_req |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 = write, 0 = read |
| reg_req_addr | output | 7 | Register word address |
| reg_req_wdata | output | 16 | Write data |
| reg_rsp_valid | input | 1 | Access complete strobe |
| reg_rsp_rdata | input | 16 | Read data, valid with reg_rsp_valid |
| seq_done | output | 1 | Sequence finished, held |
| seq_error | output | 1 | Sequence failed, held |
| lp_speed | output | 2 | Partner speed code from ability bits [11:10] |
| lp_full | output | 1 | Partner full duplex |

## Verification
The bench sweeps every duplex and speed combination of the partner ability word and checks the adapter state, error flag and reported partner fields for each. A design that enabled the adapter for a half-duplex or reserved-speed partner, or decoded the wrong bits, would show an enabled adapter or a wrong speed code. Forced mode is run at all three speeds with the interface-mode register preloaded with ones, so a read-modify-write that leaves bit 1 set or drops bit 0 gives a wrong register image. Three failure paths are exercised, and a design that treats them wrongly would either enable the adapter or miss the error flag: a reset bit that never clears, a forced link that stays down, and the reserved forced speed, which must not issue any reset write. The gap between the last poll and the status read is measured against the settle interval. The slave stalls `reg_req_ready` in a fixed pattern to catch requests that change while they wait.

// File: rtl/pcs_seq_pkg.sv
package pcs_seq_pkg;
  localparam int AW = 7;
  localparam int DW = 16;

  localparam logic [AW-1:0] A_CTRL = 7'h00;
  localparam logic [AW-1:0] A_STAT = 7'h02;
  localparam logic [AW-1:0] A_PART = 7'h0A;
  localparam logic [AW-1:0] A_LT0  = 7'h24;
  localparam logic [AW-1:0] A_LT1  = 7'h26;
  localparam logic [AW-1:0] A_IFM  = 7'h28;

  localparam logic [DW-1:0] LT0_VAL   = 16'h0D40;
  localparam logic [DW-1:0] LT1_VAL   = 16'h0003;
  localparam logic [DW-1:0] IFM_SGMII = 16'h0001;
  localparam logic [DW-1:0] ADP_ON    = 16'h0000;
  localparam logic [DW-1:0] ADP_OFF   = 16'h0001;

  localparam logic [DW-1:0] M_SRST  = 16'h8000;
  localparam logic [DW-1:0] M_ANEN  = 16'h1000;
  localparam logic [DW-1:0] M_IFAN  = 16'h0002;
  localparam logic [DW-1:0] M_IFSPD = 16'h000C;

  typedef enum logic [1:0] {
    SPD_10 = 2'b00, SPD_100 = 2'b01, SPD_1000 = 2'b10, SPD_RSVD = 2'b11
  } spd_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_IFM, ST_LT0, ST_LT1, ST_DIS, ST_CRD, ST_CWR, ST_MRD, ST_MWR,
    ST_RRD, ST_RWR, ST_POLL, ST_SETTLE, ST_STAT, ST_PART, ST_EN, ST_OK, ST_ERR
  } seq_st_e;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } bus_cmd_t;
endpackage

// File: rtl/pcs_reg_master.sv
module pcs_reg_master
  import pcs_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  bus_cmd_t      cmd,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata
);
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_WAIT} mst_e;
  mst_e     mst;
  bus_cmd_t cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst   <= M_IDLE;
      cmd_q <= '0;
    end else begin
      case (mst)
        M_IDLE: if (cmd_go) begin
          cmd_q <= cmd;
          mst   <= M_REQ;
        end
        M_REQ:  if (req_ready) mst <= M_WAIT;
        M_WAIT: if (rsp_valid) mst <= M_IDLE;
        default: mst <= M_IDLE;
      endcase
    end
  end

  assign req_valid = (mst == M_REQ);
  assign req_write = cmd_q.wr;
  assign req_addr  = cmd_q.addr;
  assign req_wdata = cmd_q.data;
  assign cmd_done  = (mst == M_WAIT) && rsp_valid;
  assign cmd_rdata = rsp_rdata;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)); // R1
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> mst == M_IDLE); // R1
endmodule

// File: rtl/pcs_cycle_timer.sv
module pcs_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_RUNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !expired |=> cnt == $past(cnt) - 1'b1); // R9
endmodule

// File: rtl/pcs_partner_decode.sv
module pcs_partner_decode
  import pcs_seq_pkg::*;
(
  input  logic [2:0] ability,
  output spd_e       spd,
  output logic       full,
  output logic       usable
);
  assign spd    = spd_e'(ability[1:0]);
  assign full   = ability[2];
  assign usable = full && (spd != SPD_RSVD);
endmodule

// File: rtl/pcs_bringup_seq.sv
module pcs_bringup_seq
  import pcs_seq_pkg::*;
#(
  parameter int            CYC_PER_MS     = 100000,
  parameter int            RST_TIMEOUT_MS = 100,
  parameter int            SETTLE_MS      = 20,
  parameter logic [AW-1:0] ADAPTER_ADDR   = 7'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_start,
  input  logic          adj_req,
  input  logic          adj_autoneg,
  input  logic [1:0]    adj_speed,
  output logic          reg_req_valid,
  input  logic          reg_req_ready,
  output logic          reg_req_write,
  output logic [AW-1:0] reg_req_addr,
  output logic [DW-1:0] reg_req_wdata,
  input  logic          reg_rsp_valid,
  input  logic [DW-1:0] reg_rsp_rdata,
  output logic          seq_done,
  output logic          seq_error,
  output logic [1:0]    lp_speed,
  output logic          lp_full
);
  localparam int TIMEOUT_CYC = CYC_PER_MS * RST_TIMEOUT_MS;
  localparam int SETTLE_CYC  = CYC_PER_MS * SETTLE_MS;
  localparam int MAX_CYC     = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int TMR_W       = $clog2(MAX_CYC + 1);

  seq_st_e       state, nxt_st;
  logic          issued, cmd_go, cmd_done, bus_st;
  logic [DW-1:0] cmd_rdata, rd_q;
  bus_cmd_t      cmd;
  logic          mode_init, mode_an;
  spd_e          mode_spd;
  logic          tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  spd_e          dec_spd;
  logic          dec_full, dec_usable;

  // ---------------- command selection per state ----------------
  always_comb begin
    cmd    = '0;
    bus_st = 1'b1;
    case (state)
      ST_IFM:  cmd = '{wr: 1'b1, addr: A_IFM, data: IFM_SGMII};
      ST_LT0:  cmd = '{wr: 1'b1, addr: A_LT0, data: LT0_VAL};
      ST_LT1:  cmd = '{wr: 1'b1, addr: A_LT1, data: LT1_VAL};
      ST_DIS:  cmd = '{wr: 1'b1, addr: ADAPTER_ADDR, data: ADP_OFF};
      ST_CRD:  cmd = '{wr: 1'b0, addr: A_CTRL, data: '0};
      ST_CWR:  cmd = '{wr: 1'b1, addr: A_CTRL,
                       data: mode_an ? (rd_q | M_ANEN) : (rd_q & ~M_ANEN)};
      ST_MRD:  cmd = '{wr: 1'b0, addr: A_IFM, data: '0};
      ST_MWR:  cmd = '{wr: 1'b1, addr: A_IFM,
                       data: mode_an ? (rd_q | M_IFAN)
                                     : ((rd_q & ~(M_IFAN | M_IFSPD)) | {12'h000, mode_spd, 2'b00})};
      ST_RRD:  cmd = '{wr: 1'b0, addr: A_CTRL, data: '0};
      ST_RWR:  cmd = '{wr: 1'b1, addr: A_CTRL, data: rd_q | M_SRST};
      ST_POLL: cmd = '{wr: 1'b0, addr: A_CTRL, data: '0};
      ST_STAT: cmd = '{wr: 1'b0, addr: A_STAT, data: '0};
      ST_PART: cmd = '{wr: 1'b0, addr: A_PART, data: '0};
      ST_EN:   cmd = '{wr: 1'b1, addr: ADAPTER_ADDR, data: ADP_ON};
      default: bus_st = 1'b0;
    endcase
  end

  assign cmd_go = bus_st && !issued;

  // ---------------- next state after an access completes ----------------
  always_comb begin
    nxt_st = state;
    case (state)
      ST_IFM:  nxt_st = ST_LT0;
      ST_LT0:  nxt_st = ST_LT1;
      ST_LT1:  nxt_st = ST_RRD;
      ST_DIS:  nxt_st = (!mode_an && mode_spd == SPD_RSVD) ? ST_ERR : ST_CRD;
      ST_CRD:  nxt_st = ST_CWR;
      ST_CWR:  nxt_st = ST_MRD;
      ST_MRD:  nxt_st = ST_MWR;
      ST_MWR:  nxt_st = ST_RRD;
      ST_RRD:  nxt_st = ST_RWR;
      ST_RWR:  nxt_st = ST_POLL;
      ST_POLL: begin
        if (!cmd_rdata[15])   nxt_st = mode_init ? ST_EN : ST_SETTLE;
        else if (tmr_expired) nxt_st = ST_ERR;
        else                  nxt_st = ST_POLL;
      end
      ST_STAT: begin
        if (mode_an) nxt_st = cmd_rdata[5] ? ST_PART : ST_ERR;
        else         nxt_st = cmd_rdata[2] ? ST_EN : ST_ERR;
      end
      ST_PART: nxt_st = dec_usable ? ST_EN : ST_ERR;
      ST_EN:   nxt_st = ST_OK;
      default: nxt_st = state;
    endcase
  end

  // ---------------- timer control ----------------
  assign tmr_load = cmd_done && ((state == ST_RWR) ||
                    (state == ST_POLL && !cmd_rdata[15] && !mode_init));
  assign tmr_val  = (state == ST_RWR) ? TMR_W'(TIMEOUT_CYC) : TMR_W'(SETTLE_CYC);

  // ---------------- main sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      issued    <= 1'b0;
      rd_q      <= '0;
      mode_init <= 1'b0;
      mode_an   <= 1'b0;
      mode_spd  <= SPD_10;
      seq_done  <= 1'b0;
      seq_error <= 1'b0;
      lp_speed  <= 2'b00;
      lp_full   <= 1'b0;
    end else begin
      if (cmd_go) issued <= 1'b1;
      if (cmd_done) begin
        issued <= 1'b0;
        rd_q   <= cmd_rdata;
      end
      case (state)
        ST_IDLE: begin
          if (init_start || adj_req) begin
            seq_done  <= 1'b0;
            seq_error <= 1'b0;
            lp_speed  <= 2'b00;
            lp_full   <= 1'b0;
            mode_init <= init_start;
            mode_an   <= adj_autoneg;
            mode_spd  <= spd_e'(adj_speed);
            state     <= init_start ? ST_IFM : ST_DIS;
          end
        end
        ST_SETTLE: if (tmr_expired) state <= ST_STAT;
        ST_OK: begin
          seq_done <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_ERR: begin
          seq_done  <= 1'b1;
          seq_error <= 1'b1;
          state     <= ST_IDLE;
        end
        default: begin
          if (cmd_done) begin
            if (state == ST_PART) begin
              lp_speed <= dec_spd;
              lp_full  <= dec_full;
            end
            state <= nxt_st;
          end
        end
      endcase
    end
  end

  pcs_reg_master u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd       (cmd),
    .cmd_done  (cmd_done),
    .cmd_rdata (cmd_rdata),
    .req_valid (reg_req_valid),
    .req_ready (reg_req_ready),
    .req_write (reg_req_write),
    .req_addr  (reg_req_addr),
    .req_wdata (reg_req_wdata),
    .rsp_valid (reg_rsp_valid),
    .rsp_rdata (reg_rsp_rdata)
  );

  pcs_cycle_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .val     (tmr_val),
    .expired (tmr_expired)
  );

  pcs_partner_decode u_decode (
    .ability (cmd_rdata[12:10]),
    .spd     (dec_spd),
    .full    (dec_full),
    .usable  (dec_usable)
  );

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> seq_done); // R4
  AST_SETTLE_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_STAT |-> tmr_expired); // R9
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !reg_req_valid); // R12
  AST_NO_RESET_RSVD_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && reg_req_write && reg_req_addr == A_CTRL && reg_req_wdata[15]
    |-> mode_init || mode_an || mode_spd != SPD_RSVD); // R8
  AST_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && reg_req_write && reg_req_addr == ADAPTER_ADDR && reg_req_wdata == ADP_ON
    && !mode_init && mode_an |-> lp_full && lp_speed != 2'b11); // R10
endmodule

// File: tb/pcs_bringup_seq_bench.sv
module pcs_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 10;
  localparam int TO_MS      = 100;
  localparam int ST_MS      = 20;
  localparam int TO_CYC     = CPM * TO_MS;
  localparam int ST_CYC     = CPM * ST_MS;
  localparam logic [6:0] ADP = 7'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_start = 1'b0, adj_req = 1'b0, adj_autoneg = 1'b0;
  logic [1:0] adj_speed = 2'b00;
  logic reg_req_valid, reg_req_ready, reg_req_write, reg_rsp_valid;
  logic [6:0] reg_req_addr;
  logic [15:0] reg_req_wdata, reg_rsp_rdata;
  logic seq_done, seq_error, lp_full;
  logic [1:0] lp_speed;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcs_bringup_seq #(.CYC_PER_MS(CPM), .RST_TIMEOUT_MS(TO_MS), .SETTLE_MS(ST_MS),
                    .ADAPTER_ADDR(ADP)) u_pcs_bringup_seq (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .adj_req(adj_req),
    .adj_autoneg(adj_autoneg), .adj_speed(adj_speed),
    .reg_req_valid(reg_req_valid), .reg_req_ready(reg_req_ready),
    .reg_req_write(reg_req_write), .reg_req_addr(reg_req_addr),
    .reg_req_wdata(reg_req_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_rdata(reg_rsp_rdata), .seq_done(seq_done), .seq_error(seq_error),
    .lp_speed(lp_speed), .lp_full(lp_full));

  int total = 0, bad = 0;
  bit finished = 0;
  int cyc = 0;

  // slave model state
  logic [15:0] regs [0:127];
  logic [6:0]  wlog_a [0:15];
  logic [15:0] wlog_d [0:15];
  int wcount = 0, rstw = 0, rst_polls = 3, rst_cnt = 0, hs_total = 0;
  bit rst_never = 0;
  int t_clr = 0, t_stat = 0, stalls = 0, stall_viol = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // register slave with a fixed ready stall pattern
  initial begin
    logic [7:0] pat = 8'b1101_0110;
    bit pend = 0, pv = 0, pr = 0, l_wr = 0;
    logic [6:0] l_a = '0, pa = '0;
    logic [15:0] l_d = '0, pd = '0;
    logic pw = 1'b0;
    for (int i = 0; i < 128; i++) regs[i] = '0;
    reg_req_ready = 1'b0; reg_rsp_valid = 1'b0; reg_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (reg_rsp_valid) reg_rsp_valid = 1'b0;
      if (pend) begin
        pend = 0;
        hs_total++;
        if (l_wr) begin
          regs[l_a] = l_d;
          if (wcount < 16) begin wlog_a[wcount] = l_a; wlog_d[wcount] = l_d; end
          wcount++;
          if (l_a == 7'h00 && l_d[15]) begin rstw++; rst_cnt = rst_polls; end
          reg_rsp_rdata = '0;
        end else begin
          if (l_a == 7'h00 && regs[0][15] && !rst_never) begin
            if (rst_cnt == 0) regs[0][15] = 1'b0;
            else rst_cnt--;
          end
          reg_rsp_rdata = regs[l_a];
          if (l_a == 7'h00 && !regs[0][15]) t_clr = cyc;
          if (l_a == 7'h02) t_stat = cyc;
        end
        reg_rsp_valid = 1'b1;
      end
      if (pv && !pr) begin
        stalls++;
        if (!(reg_req_valid && reg_req_addr == pa && reg_req_wdata == pd && reg_req_write == pw))
          stall_viol++;
      end
      reg_req_ready = pat[0] & rst_n;
      pat = {pat[0], pat[7:1]};
      pv = reg_req_valid; pr = reg_req_ready;
      pa = reg_req_addr; pd = reg_req_wdata; pw = reg_req_write;
      if (reg_req_valid && reg_req_ready) begin
        pend = 1; l_wr = reg_req_write; l_a = reg_req_addr; l_d = reg_req_wdata;
      end
    end
  end

  task automatic wait_done(output int n);
    n = 1;
    @(negedge clk);
    while (!seq_done && n < 20000) begin @(negedge clk); n++; end
    if (!seq_done) chk(1'b0, "watchdog run", 32'(n), 0);
  endtask

  task automatic run_init(output int n);
    wcount = 0;
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    wait_done(n);
  endtask

  task automatic run_adj(input bit an, input logic [1:0] spd, output int n);
    wcount = 0;
    @(negedge clk); adj_req = 1'b1; adj_autoneg = an; adj_speed = spd;
    @(negedge clk); adj_req = 1'b0;
    wait_done(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, rb, hs0;
    bit ok;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(!seq_done, "R12 reset done", 32'(seq_done), 0);
    chk(!seq_error, "R12 reset error", 32'(seq_error), 0);
    chk(!reg_req_valid, "R12 reset req_valid", 32'(reg_req_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // init success
    regs[0] = 16'h0140; regs[ADP] = 16'h0001; rst_never = 0; rst_polls = 3;
    run_init(n);
    chk(wlog_a[0] == 7'h28 && wlog_d[0] == 16'h0001, "R2 write0", {9'b0, wlog_a[0], wlog_d[0]}, 32'h0028_0001);
    chk(wlog_a[1] == 7'h24 && wlog_d[1] == 16'h0D40, "R2 write1", {9'b0, wlog_a[1], wlog_d[1]}, 32'h0024_0D40);
    chk(wlog_a[2] == 7'h26 && wlog_d[2] == 16'h0003, "R2 write2", {9'b0, wlog_a[2], wlog_d[2]}, 32'h0026_0003);
    chk(wlog_a[3] == 7'h00 && wlog_d[3] == 16'h8140, "R3 reset rmw", {16'b0, wlog_d[3]}, 32'h8140);
    chk(regs[0][15] == 1'b0, "R3 reset cleared by poll", 32'(regs[0][15]), 0);
    chk(regs[ADP] == 16'h0000 && wcount == 5, "R5 adapter enabled", 32'(regs[ADP]), 0);
    chk(seq_done && !seq_error, "R5 done ok", {seq_done, seq_error}, 2'b10);

    // R12 hold while idle
    hs0 = hs_total;
    repeat (30) @(negedge clk);
    chk(seq_done && !seq_error && hs_total == hs0, "R12 hold idle", 32'(hs_total - hs0), 0);

    // init timeout
    regs[0] = 16'h0000; regs[ADP] = 16'h0001; rst_never = 1;
    run_init(n);
    chk(seq_done && seq_error, "R4 timeout error", {seq_done, seq_error}, 2'b11);
    chk(regs[ADP] == 16'h0001, "R4 adapter not enabled", 32'(regs[ADP]), 1);
    chk(n >= TO_CYC && n < TO_CYC + 60, "R4 timeout length", 32'(n), 32'(TO_CYC));
    rst_never = 0; regs[0] = 16'h0000; rst_polls = 2;

    // auto-negotiation sweep over duplex and speed
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 4; s++) begin
        regs[0] = 16'h0000; regs[7'h28] = 16'h0001; regs[ADP] = 16'h5555;
        regs[7'h02] = 16'h0020; regs[7'h0A] = 16'((f << 12) | (s << 10));
        rb = rstw;
        run_adj(1'b1, 2'b00, n);
        ok = (f == 1) && (s != 3);
        chk(wlog_a[0] == ADP && wlog_d[0] == 16'h0001, "R6 disable first", 32'(wlog_d[0]), 1);
        chk(regs[0][12] && regs[7'h28][1], "R7 an bits", {regs[0][12], regs[7'h28][1]}, 2'b11);
        chk(rstw == rb + 1, "R3 an reset issued", 32'(rstw - rb), 1);
        chk(regs[ADP] == (ok ? 16'h0000 : 16'h0001), "R10 adapter gate", 32'(regs[ADP]), ok ? 0 : 1);
        chk(seq_error == !ok, "R10 error flag", 32'(seq_error), 32'(!ok));
        chk(lp_speed == 2'(s) && lp_full == f[0], "R10 partner report", {lp_full, lp_speed}, 32'((f << 2) | s));
        chk(t_stat - t_clr >= ST_CYC && t_stat - t_clr < ST_CYC + 30, "R9 settle", 32'(t_stat - t_clr), 32'(ST_CYC));
      end
    end

    // auto-negotiation not complete
    regs[0] = 16'h0000; regs[ADP] = 16'h5555; regs[7'h02] = 16'h0004; regs[7'h0A] = 16'h1800;
    run_adj(1'b1, 2'b00, n);
    chk(seq_error && regs[ADP] == 16'h0001, "R10 an incomplete", 32'(regs[ADP]), 1);
    chk(!lp_full && lp_speed == 2'b00, "R10 no partner read", {lp_full, lp_speed}, 0);

    // forced speeds with link up
    for (int s = 0; s < 3; s++) begin
      regs[0] = 16'h1000; regs[7'h28] = 16'h000F; regs[ADP] = 16'h5555; regs[7'h02] = 16'h0004;
      rb = rstw;
      run_adj(1'b0, 2'(s), n);
      chk(regs[0][12] == 1'b0 && rstw == rb + 1, "R8 forced ctrl", 32'(regs[0]), 0);
      chk(regs[7'h28] == 16'(1 | (s << 2)), "R8 forced ifmode", 32'(regs[7'h28]), 32'(1 | (s << 2)));
      chk(regs[ADP] == 16'h0000 && !seq_error && seq_done, "R11 forced link up", 32'(regs[ADP]), 0);
      chk(lp_speed == 2'b00 && !lp_full, "R11 partner zero", {lp_full, lp_speed}, 0);
    end

    // forced, link down
    regs[0] = 16'h0000; regs[ADP] = 16'h5555; regs[7'h02] = 16'h0020;
    run_adj(1'b0, 2'b10, n);
    chk(seq_error && regs[ADP] == 16'h0001, "R11 forced no link", 32'(regs[ADP]), 1);

    // forced reserved speed
    regs[ADP] = 16'h5555; rb = rstw;
    run_adj(1'b0, 2'b11, n);
    chk(seq_error && seq_done, "R8 reserved speed error", {seq_done, seq_error}, 2'b11);
    chk(rstw == rb && wcount == 1, "R8 no reset issued", 32'(wcount), 1);
    chk(regs[ADP] == 16'h0001, "R8 adapter stays off", 32'(regs[ADP]), 1);

    // R1 request stability under stalls
    chk(stalls > 0 && stall_viol == 0, "R1 hold under stall", 32'(stall_viol), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule